// File: doc/BRIEF.md
# Block Commit Tracker

This block follows up to eight atomic instruction blocks that are in flight in a tiled core. When a block is allocated, the allocator gives the number of register writes and the number of stores that the block will produce. While the block runs, the tiles report each register write, each store and the single branch to the tracker. A block whose reports reach every expected total, and which has reported its branch, is complete.

Blocks commit strictly in allocation order. The oldest block, once complete, is offered on a commit broadcast stream toward the register and data tiles. After the broadcast is accepted, the tracker collects one acknowledgement from each of the four register tiles and each of the four data tiles. It frees the slot only when all eight have arrived, and it signals the freed slot on a one-cycle deallocate output. Flushing a slot discards its counts and any acknowledgements already collected. The slot then returns to free without a commit and without a deallocate pulse.

Both streams use valid/ready. On the allocate stream a transfer happens on a clock edge where `alloc_valid` and `alloc_ready` are both high. `alloc_slot` names the slot that the transfer takes. While `alloc_ready` is low, `alloc_slot` holds. On the commit stream `commit_valid` never depends on `commit_ready`. Once raised, `commit_valid` and `commit_slot` hold until the transfer, unless a flush takes that slot away. Report, acknowledgement and flush pins are plain single-cycle strobes.

Top module: `ct_commit_tracker`

## Requirements
- R1: After reset every slot is free. `alloc_ready` is 1, `alloc_slot` is 0, and `commit_valid` and `dealloc_valid` are 0.
- R2: Slots are handed out in increasing order, wrapping from 7 to 0. `alloc_ready` is low whenever the slot named by `alloc_slot` is still in flight, so at most eight blocks are held.
- R3: A block is complete once it has reported exactly its expected register writes, exactly its expected stores, and one branch. `commit_valid` rises for it in the cycle after the clock edge that captures the last of these reports.
- R4: Only the oldest in-flight block can be offered for commit. A younger complete block waits until every older block has been freed or flushed.
- R5: While `commit_ready` is low, `commit_valid` and `commit_slot` hold. After the transfer, `commit_valid` drops until the next block qualifies.
- R6: Acknowledgement bits 0 to 3 belong to the register tiles and bits 4 to 7 to the data tiles. They may arrive in any grouping, over any number of cycles, and may repeat. The slot is freed once all eight are seen. `dealloc_valid` pulses for one cycle, with `dealloc_slot`, in the cycle after the edge that captures the last missing bit.
- R7: A slot whose `flush_mask` bit is set is freed at that edge with no commit and no deallocate pulse. Counts and acknowledgements it had gathered are lost and do not carry into the next block in that slot.
- R8: Reports aimed at a free slot, and acknowledgements while no block awaits them, have no effect.
- R9: A block allocated with zero writes and zero stores becomes complete on its branch alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Slot named by alloc_slot is free |
| alloc_slot | output | 3 | Slot the next allocation takes |
| alloc_wr_cnt | input | 6 | Expected register writes (0..32) |
| alloc_st_cnt | input | 6 | Expected stores (0..32) |
| wr_rep_v | input | 1 | One register write produced |
| wr_rep_slot | input | 3 | Slot of that write |
| st_rep_v | input | 1 | One store completed |
| st_rep_slot | input | 3 | Slot of that store |
| br_rep_v | input | 1 | Branch produced |
| br_rep_slot | input | 3 | Slot of that branch |
| commit_valid | output | 1 | Commit broadcast offered |
| commit_ready | input | 1 | Broadcast network accepts |
| commit_slot | output | 3 | Slot being committed |
| commit_ack | input | 8 | Per-tile commit acknowledgements |
| dealloc_valid | output | 1 | One-cycle slot-freed pulse |
| dealloc_slot | output | 3 | Freed slot |
| flush_mask | input | 8 | Slots to flush this cycle |

## Verification
The assertions take for granted that no block reports more writes or stores than it was allocated, and that no block reports a second branch. They also assume that a flush never names the slot being allocated in the same cycle. The stimulus derives every report from the counts it has just allocated, sends each branch once, and flushes only slots that already hold blocks. A behavioural model in the bench keeps an age-ordered queue of in-flight slots and is compared against the ports on every clock.

// File: rtl/ct_pkg.sv
package ct_pkg;
  typedef enum logic [1:0] {
    SL_FREE = 2'd0,
    SL_RUN  = 2'd1,
    SL_WAIT = 2'd2
  } slot_st_e;
endpackage

// File: rtl/ct_slot.sv
module ct_slot
  import ct_pkg::*;
#(
  parameter int CW   = 6,
  parameter int NACK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_i,
  input  logic [CW-1:0]   exp_wr_i,
  input  logic [CW-1:0]   exp_st_i,
  input  logic            wr_i,
  input  logic            st_i,
  input  logic            br_i,
  input  logic            flush_i,
  input  logic            send_i,
  input  logic [NACK-1:0] ack_i,
  output slot_st_e        state_o,
  output logic            done_o,
  output logic            freed_o
);
  slot_st_e        state_q;
  logic [CW-1:0]   ewr_q, est_q, wr_q, st_q;
  logic            br_q;
  logic [NACK-1:0] ack_q;
  logic [NACK-1:0] ack_all;

  assign ack_all = ack_q | ack_i;
  assign state_o = state_q;
  assign done_o  = (state_q == SL_RUN) && br_q && (wr_q == ewr_q) && (st_q == est_q);
  assign freed_o = (state_q == SL_WAIT) && !flush_i && (&ack_all);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SL_FREE;
      ewr_q   <= '0;
      est_q   <= '0;
      wr_q    <= '0;
      st_q    <= '0;
      br_q    <= 1'b0;
      ack_q   <= '0;
    end else if (flush_i) begin
      state_q <= SL_FREE;
      ack_q   <= '0;
      br_q    <= 1'b0;
    end else begin
      case (state_q)
        SL_FREE: if (alloc_i) begin
          state_q <= SL_RUN;
          ewr_q   <= exp_wr_i;
          est_q   <= exp_st_i;
          wr_q    <= '0;
          st_q    <= '0;
          br_q    <= 1'b0;
        end
        SL_RUN: begin
          if (wr_i) wr_q <= wr_q + CW'(1);
          if (st_i) st_q <= st_q + CW'(1);
          if (br_i) br_q <= 1'b1;
          if (send_i) begin
            state_q <= SL_WAIT;
            ack_q   <= '0;
          end
        end
        SL_WAIT: begin
          ack_q <= ack_all;
          if (&ack_all) state_q <= SL_FREE;
        end
        default: state_q <= SL_FREE;
      endcase
    end
  end

  // R7
  flush_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> state_q == SL_FREE);

  // R3
  wr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SL_RUN && wr_i && !flush_i) |-> wr_q < ewr_q);

  // R3
  st_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SL_RUN && st_i && !flush_i) |-> st_q < est_q);

  // R3
  one_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SL_RUN && br_i && !flush_i) |-> !br_q);
endmodule

// File: rtl/ct_oldest.sv
module ct_oldest #(
  parameter int N  = 8,
  parameter int SW = 3
) (
  input  logic [N-1:0]  busy_i,
  input  logic [SW-1:0] start_i,
  output logic          found_o,
  output logic [SW-1:0] idx_o
);
  always_comb begin
    int k;
    found_o = 1'b0;
    idx_o   = start_i;
    for (int i = N - 1; i >= 0; i--) begin
      k = int'(start_i) + i;
      if (k >= N) k = k - N;
      if (busy_i[k]) begin
        found_o = 1'b1;
        idx_o   = SW'(k);
      end
    end
  end
endmodule

// File: rtl/ct_commit_tracker.sv
module ct_commit_tracker
  import ct_pkg::*;
#(
  parameter int NSLOT   = 8,
  parameter int NREG_T  = 4,
  parameter int NDATA_T = 4,
  parameter int MAX_OUT = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              alloc_valid,
  output logic                              alloc_ready,
  output logic [$clog2(NSLOT)-1:0]          alloc_slot,
  input  logic [$clog2(MAX_OUT+1)-1:0]      alloc_wr_cnt,
  input  logic [$clog2(MAX_OUT+1)-1:0]      alloc_st_cnt,
  input  logic                              wr_rep_v,
  input  logic [$clog2(NSLOT)-1:0]          wr_rep_slot,
  input  logic                              st_rep_v,
  input  logic [$clog2(NSLOT)-1:0]          st_rep_slot,
  input  logic                              br_rep_v,
  input  logic [$clog2(NSLOT)-1:0]          br_rep_slot,
  output logic                              commit_valid,
  input  logic                              commit_ready,
  output logic [$clog2(NSLOT)-1:0]          commit_slot,
  input  logic [NREG_T+NDATA_T-1:0]         commit_ack,
  output logic                              dealloc_valid,
  output logic [$clog2(NSLOT)-1:0]          dealloc_slot,
  input  logic [NSLOT-1:0]                  flush_mask
);
  localparam int SW   = $clog2(NSLOT);
  localparam int CW   = $clog2(MAX_OUT + 1);
  localparam int NACK = NREG_T + NDATA_T;

  logic [SW-1:0]  tail_q;
  slot_st_e       st_w [NSLOT];
  logic [NSLOT-1:0] busy, waiting, done, freed;
  logic           old_found;
  logic [SW-1:0]  old_idx;
  logic           alloc_fire, commit_fire;
  logic           dv_q;
  logic [SW-1:0]  ds_q;
  logic [SW-1:0]  freed_idx;

  assign alloc_ready  = (st_w[tail_q] == SL_FREE);
  assign alloc_slot   = tail_q;
  assign alloc_fire   = alloc_valid && alloc_ready;
  assign commit_valid = old_found && (st_w[old_idx] == SL_RUN) && done[old_idx];
  assign commit_slot  = old_idx;
  assign commit_fire  = commit_valid && commit_ready;
  assign dealloc_valid = dv_q;
  assign dealloc_slot  = ds_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    ct_slot #(.CW(CW), .NACK(NACK)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_i  (alloc_fire && (tail_q == SW'(g))),
      .exp_wr_i (alloc_wr_cnt),
      .exp_st_i (alloc_st_cnt),
      .wr_i     (wr_rep_v && (wr_rep_slot == SW'(g))),
      .st_i     (st_rep_v && (st_rep_slot == SW'(g))),
      .br_i     (br_rep_v && (br_rep_slot == SW'(g))),
      .flush_i  (flush_mask[g]),
      .send_i   (commit_fire && (old_idx == SW'(g))),
      .ack_i    (commit_ack),
      .state_o  (st_w[g]),
      .done_o   (done[g]),
      .freed_o  (freed[g])
    );
    assign busy[g]    = (st_w[g] != SL_FREE);
    assign waiting[g] = (st_w[g] == SL_WAIT);
  end

  ct_oldest #(.N(NSLOT), .SW(SW)) u_oldest (
    .busy_i  (busy),
    .start_i (tail_q),
    .found_o (old_found),
    .idx_o   (old_idx)
  );

  always_comb begin
    freed_idx = '0;
    for (int i = 0; i < NSLOT; i++)
      if (freed[i]) freed_idx = SW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
      dv_q   <= 1'b0;
      ds_q   <= '0;
    end else begin
      if (alloc_fire)
        tail_q <= (tail_q == SW'(NSLOT - 1)) ? '0 : tail_q + SW'(1);
      dv_q <= |freed;
      if (|freed) ds_q <= freed_idx;
    end
  end

  // R4
  single_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(waiting));

  // R5
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !commit_ready && !(|flush_mask)) |=> (commit_valid && $stable(commit_slot)));

  // R2
  alloc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready) |=> $stable(alloc_slot));
endmodule

// File: tb/sim_ct_commit_tracker.sv
module sim_ct_commit_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, commit_ready = 1;
  logic alloc_ready, commit_valid, dealloc_valid;
  logic [2:0] alloc_slot, commit_slot, dealloc_slot;
  logic [5:0] alloc_wr_cnt = 0, alloc_st_cnt = 0;
  logic wr_rep_v = 0, st_rep_v = 0, br_rep_v = 0;
  logic [2:0] wr_rep_slot = 0, st_rep_slot = 0, br_rep_slot = 0;
  logic [7:0] commit_ack = 0, flush_mask = 0;

  int checks = 0, errors = 0, cyc = 0;
  string cur = "R1";

  always #5 clk = ~clk;

  ct_commit_tracker u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_slot(alloc_slot),
    .alloc_wr_cnt(alloc_wr_cnt), .alloc_st_cnt(alloc_st_cnt),
    .wr_rep_v(wr_rep_v), .wr_rep_slot(wr_rep_slot),
    .st_rep_v(st_rep_v), .st_rep_slot(st_rep_slot),
    .br_rep_v(br_rep_v), .br_rep_slot(br_rep_slot),
    .commit_valid(commit_valid), .commit_ready(commit_ready), .commit_slot(commit_slot),
    .commit_ack(commit_ack),
    .dealloc_valid(dealloc_valid), .dealloc_slot(dealloc_slot),
    .flush_mask(flush_mask)
  );

  // behavioural reference: 0 free, 1 running, 2 awaiting acks
  int m_s[8], m_wr[8], m_sc[8], m_br[8], m_ew[8], m_es[8], m_ak[8];
  int ord[$];
  int m_t = 0, e_dv = 0, e_ds = 0;

  function automatic bit cmpl(int s);
    return m_br[s] == 1 && m_wr[s] == m_ew[s] && m_sc[s] == m_es[s];
  endfunction

  function automatic bit exp_cv();
    if (ord.size() == 0) return 0;
    return m_s[ord[0]] == 1 && cmpl(ord[0]);
  endfunction

  always @(posedge clk) begin
    bit fire, rdy0;
    int h;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_s[i] = 0; m_ak[i] = 0; m_br[i] = 0; end
      ord.delete(); m_t = 0; e_dv = 0; e_ds = 0;
    end else begin
      fire = exp_cv() && commit_ready;
      rdy0 = (m_s[m_t] == 0);
      h = (ord.size() > 0) ? ord[0] : 0;
      e_dv = 0;
      if (wr_rep_v && m_s[wr_rep_slot] == 1) m_wr[wr_rep_slot]++;
      if (st_rep_v && m_s[st_rep_slot] == 1) m_sc[st_rep_slot]++;
      if (br_rep_v && m_s[br_rep_slot] == 1) m_br[br_rep_slot] = 1;
      if (ord.size() > 0 && m_s[h] == 2) begin
        m_ak[h] |= int'(commit_ack);
        if (m_ak[h] == 255) begin
          e_dv = 1; e_ds = h; m_s[h] = 0; void'(ord.pop_front());
        end
      end
      if (fire) begin m_s[h] = 2; m_ak[h] = 0; end
      if (alloc_valid && rdy0) begin
        m_s[m_t] = 1; m_ew[m_t] = int'(alloc_wr_cnt); m_es[m_t] = int'(alloc_st_cnt);
        m_wr[m_t] = 0; m_sc[m_t] = 0; m_br[m_t] = 0;
        ord.push_back(m_t); m_t = (m_t + 1) % 8;
      end
      for (int i = 0; i < 8; i++) if (flush_mask[i]) begin
        if (e_dv == 1 && e_ds == i) e_dv = 0;
        for (int j = ord.size() - 1; j >= 0; j--) if (ord[j] == i) ord.delete(j);
        m_s[i] = 0; m_ak[i] = 0; m_br[i] = 0;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act %0d exp %0d", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(alloc_ready == (m_s[m_t] == 0), "R2", "alloc_ready", alloc_ready, m_s[m_t] == 0);
      chk(int'(alloc_slot) == m_t, "R2", "alloc_slot", alloc_slot, m_t);
      chk(commit_valid == exp_cv(), cur, "commit_valid R4", commit_valid, exp_cv());
      if (exp_cv()) chk(int'(commit_slot) == ord[0], cur, "commit_slot R4", commit_slot, ord[0]);
      chk(int'(dealloc_valid) == e_dv, cur, "dealloc_valid R6", dealloc_valid, e_dv);
      if (e_dv == 1) chk(int'(dealloc_slot) == e_ds, cur, "dealloc_slot R6", dealloc_slot, e_ds);
    end
  end

  task automatic nx();
    @(negedge clk);
    alloc_valid = 0; wr_rep_v = 0; st_rep_v = 0; br_rep_v = 0;
    commit_ack = 0; flush_mask = 0;
  endtask

  task automatic alloc_blk(int w, int s, output int sl);
    nx();
    alloc_valid = 1; alloc_wr_cnt = 6'(w); alloc_st_cnt = 6'(s);
    sl = int'(alloc_slot);
  endtask

  task automatic rep_all(int sl, int w, int s);
    for (int i = 0; i < w; i++) begin nx(); wr_rep_v = 1; wr_rep_slot = 3'(sl); end
    for (int i = 0; i < s; i++) begin nx(); st_rep_v = 1; st_rep_slot = 3'(sl); end
    nx(); br_rep_v = 1; br_rep_slot = 3'(sl);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) nx();
  endtask

  task automatic ack(logic [7:0] v);
    nx(); commit_ack = v;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++; checks++;
      $display("FAIL watchdog R1 act hung exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a, b, c;
    int sl[9];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur = "R1";
    chk(alloc_ready == 1, "R1", "alloc_ready", alloc_ready, 1);
    chk(alloc_slot == 0, "R1", "alloc_slot", alloc_slot, 0);
    chk(commit_valid == 0, "R1", "commit_valid", commit_valid, 0);
    chk(dealloc_valid == 0, "R1", "dealloc_valid", dealloc_valid, 0);

    cur = "R3";
    alloc_blk(2, 1, a);
    rep_all(a, 2, 1);
    nx();
    chk(commit_valid == 1, "R3", "commit_valid after last report", commit_valid, 1);
    ack(8'hFF); idle(2);

    cur = "R9";
    alloc_blk(0, 0, a);
    nx(); br_rep_v = 1; br_rep_slot = 3'(a);
    nx();
    chk(commit_valid == 1 && int'(commit_slot) == a, "R9", "zero-count commit", commit_slot, a);
    ack(8'hFF); idle(2);

    cur = "R4";
    alloc_blk(1, 0, a);
    alloc_blk(0, 1, b);
    rep_all(b, 0, 1);
    idle(3);
    chk(commit_valid == 0, "R4", "younger held", commit_valid, 0);
    rep_all(a, 1, 0);
    nx();
    chk(int'(commit_slot) == a, "R4", "oldest first", commit_slot, a);
    ack(8'hFF); idle(1); ack(8'hFF); idle(2);

    cur = "R5";
    commit_ready = 0;
    alloc_blk(0, 0, a);
    nx(); br_rep_v = 1; br_rep_slot = 3'(a);
    idle(4);
    chk(commit_valid == 1 && int'(commit_slot) == a, "R5", "held under back-pressure", commit_valid, 1);
    commit_ready = 1;
    nx();
    chk(commit_valid == 0, "R5", "drops after transfer", commit_valid, 0);

    cur = "R6";
    ack(8'h0F); ack(8'h30); ack(8'h30);
    nx();
    chk(dealloc_valid == 0, "R6", "partial acks keep slot", dealloc_valid, 0);
    ack(8'hC0);
    nx();
    chk(dealloc_valid == 1 && int'(dealloc_slot) == a, "R6", "dealloc after last ack", dealloc_slot, a);
    idle(2);

    cur = "R7";
    alloc_blk(1, 1, a);
    alloc_blk(0, 0, b);
    nx(); br_rep_v = 1; br_rep_slot = 3'(b);
    nx(); flush_mask = 8'(1 << a);
    idle(2);
    ack(8'h0F);
    nx(); flush_mask = 8'(1 << b);
    idle(3);
    chk(dealloc_valid == 0, "R7", "no dealloc after flush", dealloc_valid, 0);
    alloc_blk(0, 0, c);
    nx(); br_rep_v = 1; br_rep_slot = 3'(c);
    idle(2);
    ack(8'hF0);
    nx();
    chk(dealloc_valid == 0, "R7", "stale acks discarded", dealloc_valid, 0);
    ack(8'h0F); idle(2);

    cur = "R8";
    c = int'(alloc_slot);
    nx(); wr_rep_v = 1; wr_rep_slot = 3'(c); st_rep_v = 1; st_rep_slot = 3'(c);
    br_rep_v = 1; br_rep_slot = 3'(c); commit_ack = 8'hFF;
    alloc_blk(1, 0, a);
    nx(); wr_rep_v = 1; wr_rep_slot = 3'(a);
    idle(3);
    chk(commit_valid == 0, "R8", "earlier reports ignored", commit_valid, 0);
    nx(); br_rep_v = 1; br_rep_slot = 3'(a);
    idle(1); ack(8'hFF); idle(2);

    cur = "R2";
    commit_ready = 0;
    for (int i = 0; i < 9; i++) begin
      nx(); alloc_valid = 1; alloc_wr_cnt = 0; alloc_st_cnt = 0;
      sl[i] = int'(alloc_slot);
      if (i == 8) chk(alloc_ready == 0, "R2", "full ring stalls", alloc_ready, 0);
    end
    chk(sl[8] == sl[0], "R2", "stalled slot is oldest", sl[8], sl[0]);
    for (int i = 7; i >= 0; i--) begin nx(); br_rep_v = 1; br_rep_slot = 3'(sl[i]); end
    commit_ready = 1;
    for (int i = 0; i < 8; i++) begin nx(); nx(); commit_ack = 8'hFF; end
    idle(3);
    chk(alloc_ready == 1, "R2", "ring drained", alloc_ready, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule